// File: doc/BRIEF.md
# Fetch Strobe and Return-from-Interrupt Refetch Sequencer

This block sits beside the bus-cycle logic of a small CPU core. It drives an active-low strobe that marks the first machine cycle of an instruction. The core reports each machine cycle with a valid flag and a cycle type: opcode fetch, maskable interrupt acknowledge, or the first cycle of a non-maskable acknowledge. For opcode fetches it also supplies the fetched byte. A mode register at I/O address 3Eh sets how the strobe behaves.

With the strobe-enable bit set, which is the reset state, every fetch and acknowledge cycle is strobed. The two-byte return-from-interrupt opcode (EDh then 4Dh) is fetched only once.

With the strobe-enable bit cleared, no cycle is strobed. The one exception is the return-from-interrupt opcode. After it has been fetched once with normal timing, the block raises a one-clock refetch request to the fetch unit. The fetch unit then repeats both bytes, and the block strobes those two fetch cycles so that external peripherals can decode the opcode.

A write with bit 6 cleared forces the strobe low for the single clock after the write.

Top module: `cycle_strobe_seq`

## Requirements
- R1: After reset the strobe is high, the refetch request is low, and a read of address 3Eh returns FFh.
- R2: With bit 7 of the mode register at 1, the strobe is low in the same clock as any valid cycle flagged as opcode fetch, maskable acknowledge or first non-maskable acknowledge cycle. It is high in every other clock, unless R7 applies.
- R3: With bit 7 at 0, no fetch or acknowledge cycle drives the strobe low, except the refetch cycles of R5 and the clock of R7.
- R4: With bit 7 at 1, fetching EDh followed by 4Dh never raises the refetch request.
- R5: With bit 7 at 0, a fetch of 4Dh whose preceding fetch was EDh raises the refetch request for exactly one clock, in the clock after that fetch. The next two fetch cycles are then strobed, and fetch cycles after those are not.
- R6: Opcode pairing counts fetch cycles only. Non-fetch cycles between EDh and 4Dh do not break the pair. Any other fetched byte between them does break it, and a 4Dh not preceded by EDh does nothing.
- R7: A write to 3Eh with bit 6 at 0 drives the strobe low for exactly the one clock after the write, whatever the cycle inputs are.
- R8: Bits 7 and 5 of 3Eh are writable and read back as written. Bit 6 and bits 4..0 always read 1, and writes to them do not change what is read.
- R9: Reads of any other address return 00h, and writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_valid | input | 1 | A machine cycle is reported in this clock |
| cyc_fetch | input | 1 | The cycle is an opcode fetch |
| cyc_intack | input | 1 | The cycle is a maskable interrupt acknowledge |
| cyc_nmi_first | input | 1 | The cycle is the first cycle of a non-maskable acknowledge |
| cyc_opcode | input | 8 | Byte fetched in an opcode fetch cycle |
| io_addr | input | 8 | I/O address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data; 00h unless reading 3Eh |
| strobe_n | output | 1 | Active-low first-cycle strobe |
| refetch_req | output | 1 | One-clock request to repeat the return-from-interrupt fetch |

## Verification
A wrong mode bit shows at once: the next fetch or acknowledge cycle has the wrong strobe level, and a read of 3Eh shows the bad value in the same clock. A fault in the opcode-pairing state stays hidden until a 4Dh fetch. It then appears as a missing or unexpected refetch request one clock later, and as a wrong strobe on the two fetches that follow. A stuck one-clock override shows on the first idle clock after a write.

// File: rtl/csq_pkg.sv
package csq_pkg;
  localparam int unsigned DATA_W = 8;
  localparam logic [DATA_W-1:0] OP_PREFIX = 8'hED;
  localparam logic [DATA_W-1:0] OP_RETURN = 8'h4D;
  localparam int unsigned BIT_EN   = 7;
  localparam int unsigned BIT_TMP  = 6;
  localparam int unsigned BIT_COMP = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PFX  = 2'd1,
    ST_RF1  = 2'd2,
    ST_RF2  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/csq_rst_sync.sv
module csq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/csq_mode_reg.sv
module csq_mode_reg
  import csq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h3E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              mode_en,
  output logic              temp_pend
);
  logic wr_hit, rd_hit;
  logic en_d, comp_d, tmp_d;
  logic comp_q;

  assign wr_hit = io_wr && (io_addr == REG_ADDR);
  assign rd_hit = io_rd && (io_addr == REG_ADDR);

  always_comb begin
    en_d   = mode_en;
    comp_d = comp_q;
    tmp_d  = 1'b0;
    if (wr_hit) begin
      en_d   = io_wdata[BIT_EN];
      comp_d = io_wdata[BIT_COMP];
      tmp_d  = ~io_wdata[BIT_TMP];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_en   <= 1'b1;
      comp_q    <= 1'b1;
      temp_pend <= 1'b0;
    end else begin
      mode_en   <= en_d;
      comp_q    <= comp_d;
      temp_pend <= tmp_d;
    end
  end

  always_comb begin
    io_rdata = '0;
    if (rd_hit) begin
      io_rdata           = '1;
      io_rdata[BIT_EN]   = mode_en;
      io_rdata[BIT_COMP] = comp_q;
    end
  end
endmodule

// File: rtl/csq_reti_fsm.sv
module csq_reti_fsm
  import csq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_ev,
  input  logic [DATA_W-1:0] opcode,
  input  logic              mode_en,
  output logic              refetch_req,
  output logic              rf_busy
);
  seq_state_e state_q, state_d;
  logic       req_d;

  always_comb begin
    state_d = state_q;
    req_d   = 1'b0;
    if (fetch_ev) begin
      unique case (state_q)
        ST_RF1: state_d = ST_RF2;
        ST_RF2: state_d = ST_IDLE;
        default: begin
          if (state_q == ST_PFX && opcode == OP_RETURN && !mode_en) begin
            state_d = ST_RF1;
            req_d   = 1'b1;
          end else if (opcode == OP_PREFIX) begin
            state_d = ST_PFX;
          end else begin
            state_d = ST_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      refetch_req <= 1'b0;
    end else begin
      state_q     <= state_d;
      refetch_req <= req_d;
    end
  end

  assign rf_busy = (state_q == ST_RF1) || (state_q == ST_RF2);
endmodule

// File: rtl/cycle_strobe_seq.sv
module cycle_strobe_seq
  import csq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h3E,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_valid,
  input  logic              cyc_fetch,
  input  logic              cyc_intack,
  input  logic              cyc_nmi_first,
  input  logic [7:0]        cyc_opcode,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              strobe_n,
  output logic              refetch_req
);
  logic rst_s_n;
  logic mode_en, temp_pend, rf_busy;
  logic fetch_ev, ack_ev;

  csq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  csq_mode_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_mode (
    .clk(clk), .rst_n(rst_s_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .mode_en(mode_en), .temp_pend(temp_pend)
  );

  assign fetch_ev = cyc_valid && cyc_fetch;
  assign ack_ev   = cyc_valid && (cyc_intack || cyc_nmi_first);

  csq_reti_fsm u_fsm (
    .clk(clk), .rst_n(rst_s_n), .fetch_ev(fetch_ev), .opcode(cyc_opcode),
    .mode_en(mode_en), .refetch_req(refetch_req), .rf_busy(rf_busy)
  );

  always_comb begin
    strobe_n = 1'b1;
    if (temp_pend)                            strobe_n = 1'b0;
    else if (mode_en && (fetch_ev || ack_ev)) strobe_n = 1'b0;
    else if (rf_busy && fetch_ev)             strobe_n = 1'b0;
  end
endmodule

// File: rtl/csq_checker.sv
module csq_checker (
  input logic       clk,
  input logic       rst_s_n,
  input logic       cyc_valid,
  input logic       cyc_fetch,
  input logic       cyc_intack,
  input logic       cyc_nmi_first,
  input logic [7:0] io_addr,
  input logic       io_wr,
  input logic [7:0] io_wdata,
  input logic       strobe_n,
  input logic       refetch_req,
  input logic       mode_en,
  input logic       temp_pend,
  input logic       rf_busy
);
  AST_EN_STROBE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode_en && cyc_valid && (cyc_fetch || cyc_intack || cyc_nmi_first)) |-> !strobe_n); // R2
  AST_QUIET_MODE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!mode_en && !temp_pend && !rf_busy) |-> strobe_n); // R3
  AST_NO_REQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_s_n)
    refetch_req |-> !$past(mode_en)); // R4
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_s_n)
    refetch_req |=> !refetch_req); // R5
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_s_n)
    refetch_req |-> rf_busy); // R5
  AST_TEMP_ONE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (io_wr && io_addr == 8'h3E && !io_wdata[6]) |=> !strobe_n); // R7
endmodule

bind cycle_strobe_seq csq_checker u_chk (
  .clk(clk), .rst_s_n(rst_s_n), .cyc_valid(cyc_valid), .cyc_fetch(cyc_fetch),
  .cyc_intack(cyc_intack), .cyc_nmi_first(cyc_nmi_first), .io_addr(io_addr),
  .io_wr(io_wr), .io_wdata(io_wdata), .strobe_n(strobe_n),
  .refetch_req(refetch_req), .mode_en(mode_en), .temp_pend(temp_pend),
  .rf_busy(rf_busy)
);

// File: tb/cycle_strobe_seq_bench.sv
module cycle_strobe_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_valid = 0, cyc_fetch = 0, cyc_intack = 0, cyc_nmi_first = 0;
  logic [7:0] cyc_opcode = 8'h00;
  logic [7:0] io_addr = 8'h00;
  logic       io_wr = 0, io_rd = 0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic       strobe_n, refetch_req;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference state
  bit m_en = 1, m_comp = 1, m_temp = 0, m_saw = 0, m_req = 0;
  int m_rf = 0;
  int m_sync = 0;

  always #5 clk = ~clk;

  cycle_strobe_seq u_cycle_strobe_seq (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_fetch(cyc_fetch),
    .cyc_intack(cyc_intack), .cyc_nmi_first(cyc_nmi_first), .cyc_opcode(cyc_opcode),
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .strobe_n(strobe_n), .refetch_req(refetch_req)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 1; m_comp = 1; m_temp = 0; m_saw = 0; m_req = 0; m_rf = 0; m_sync = 0;
    end else begin
      if (m_sync >= 2) begin
        bit hit;
        bit old_en;
        hit = io_wr && io_addr == 8'h3E;
        old_en = m_en;
        m_temp = hit && !io_wdata[6];
        if (hit) begin m_en = io_wdata[7]; m_comp = io_wdata[5]; end
        m_req = 0;
        if (cyc_valid && cyc_fetch) begin
          if (m_rf > 0) begin
            m_rf = m_rf - 1;
            m_saw = 0;
          end else if (m_saw && cyc_opcode == 8'h4D && !old_en) begin
            m_req = 1; m_rf = 2; m_saw = 0;
          end else begin
            m_saw = (cyc_opcode == 8'hED);
          end
        end
      end
      if (m_sync < 2) m_sync++;
    end
  end

  always @(negedge clk) begin
    bit e_str;
    logic [7:0] e_rd;
    if (!done) begin
      e_str = !(m_temp || (cyc_valid && ((m_en && (cyc_fetch || cyc_intack || cyc_nmi_first))
                                         || (m_rf > 0 && cyc_fetch))));
      e_rd = (io_rd && io_addr == 8'h3E) ? {m_en, 1'b1, m_comp, 5'h1F} : 8'h00;
      compared++;
      if (strobe_n !== e_str || refetch_req !== m_req || io_rdata !== e_rd) begin
        mismatched++;
        $display("FAIL %s t=%0t strobe_n=%b/%b refetch_req=%b/%b io_rdata=%h/%h (actual/expected)",
                 cur_req, $time, strobe_n, e_str, refetch_req, m_req, io_rdata, e_rd);
      end
    end
  end

  task automatic idle_inputs();
    cyc_valid = 0; cyc_fetch = 0; cyc_intack = 0; cyc_nmi_first = 0;
    cyc_opcode = 8'h00; io_wr = 0; io_rd = 0; io_addr = 8'h00; io_wdata = 8'h00;
  endtask

  task automatic step();
    @(posedge clk); #1;
    idle_inputs();
  endtask

  task automatic fetch(input logic [7:0] b);
    @(posedge clk); #1;
    idle_inputs();
    cyc_valid = 1; cyc_fetch = 1; cyc_opcode = b;
  endtask

  task automatic ack(input bit nmi);
    @(posedge clk); #1;
    idle_inputs();
    cyc_valid = 1;
    if (nmi) cyc_nmi_first = 1; else cyc_intack = 1;
  endtask

  task automatic plain_cycle();
    @(posedge clk); #1;
    idle_inputs();
    cyc_valid = 1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    idle_inputs();
    io_wr = 1; io_addr = a; io_wdata = d;
  endtask

  task automatic rd(input logic [7:0] a);
    @(posedge clk); #1;
    idle_inputs();
    io_rd = 1; io_addr = a;
  endtask

  initial begin
    #(200_000 * 10);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state and readback FFh
    cur_req = "R1";
    repeat (4) step();
    rd(8'h3E); step();
    // R2: strobed cycles with enable set
    cur_req = "R2";
    fetch(8'h00); ack(0); ack(1); plain_cycle(); step(); fetch(8'h12);
    // R4: pair fetched once with enable set
    cur_req = "R4";
    fetch(8'hED); fetch(8'h4D); fetch(8'h00); step(); step();
    // R8: writable bits and fixed ones
    cur_req = "R8";
    wr(8'h3E, 8'h5F); rd(8'h3E); wr(8'h3E, 8'h40); rd(8'h3E); step();
    // R3: quiet mode
    cur_req = "R3";
    fetch(8'h00); ack(0); ack(1); fetch(8'h4D); step();
    // R5: refetch in compatible mode
    cur_req = "R5";
    fetch(8'hED); fetch(8'h4D); step(); fetch(8'hED); plain_cycle(); fetch(8'h4D);
    fetch(8'h00); fetch(8'h01); step();
    // R6: pairing rules
    cur_req = "R6";
    fetch(8'hED); ack(0); step(); fetch(8'h4D); fetch(8'hED); fetch(8'h4D); fetch(8'h00);
    fetch(8'h4D); step();
    fetch(8'hED); fetch(8'h00); fetch(8'h4D); step();
    fetch(8'hED); fetch(8'hED); fetch(8'h4D); fetch(8'hED); fetch(8'h4D); fetch(8'h00); step();
    // R7: one-clock override
    cur_req = "R7";
    wr(8'h3E, 8'h00); step(); step(); wr(8'h3E, 8'h20); fetch(8'h00); step();
    // R9: other addresses
    cur_req = "R9";
    wr(8'h3F, 8'hFF); rd(8'h3F); rd(8'h3E); wr(8'h00, 8'h00); step(); fetch(8'h00);
    // back to enabled mode
    cur_req = "R8";
    wr(8'h3E, 8'hA0); rd(8'h3E); fetch(8'h00);
    cur_req = "R4";
    fetch(8'hED); fetch(8'h4D); step(); step();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule